// File: doc/BRIEF.md
# Bridge Configuration Register File

This block is the device-side register space of a video bridge that converts a serial display link into a parallel differential panel link. A host, after its serial transport is decoded elsewhere, reaches the space through a simple one-cycle register port. The port has an 8-bit address, 8-bit write data, a write strobe and a read strobe. The block holds read-only identification bytes and the reset, clock-range and PLL controls. It also holds the PLL lock flag and the interrupt machinery, and it drives a level interrupt line.

A PLL model supplies a lock level. The receive logic supplies single-cycle error event pulses, one per status source. Each status flag is sticky until software writes a one to it. The usual service sequence is to read the status byte and write the same value back, which clears exactly the flags that were reported. A flag whose event arrives in the same cycle as its clear stays set.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, every writable register and status flag reads 0x00. `soft_reset_out`, `pll_en_out`, `pll_locked_out`, `irq_out`, `clk_range_out` and `clk_src_out` are all 0.
- R2: Addresses 0x00 to 0x08 return identification byte n, which is bits [8n+7:8n] of the `ID_VALUE` parameter. Writes to these addresses change nothing.
- R3: Writing a 1 to bit 0 of address 0x09 raises `soft_reset_out` for exactly one cycle, starting at the clock edge that takes the write. The bit then clears by itself, so a later read of 0x09 returns 0x00.
- R4: Address 0x0A holds the clock range in bits 3:1 (driving `clk_range_out`) and the clock-source select in bit 0 (driving `clk_src_out`). Bits 6:4 read 0. Bit 7 is the lock flag and cannot be written.
- R5: Bit 0 of address 0x0D drives `pll_en_out`. The lock flag (bit 7 of 0x0A and `pll_locked_out`) is 1 only while that bit is set and `pll_lock_in` was high at the previous clock edge. It falls at the same edge that clears the enable.
- R6: Bit 0 of address 0xE0 is the global interrupt enable. Address 0xE1 holds the per-source enables, laid out like the status byte, and its bit 1 always reads 0.
- R7: The status byte at 0xE5 has this layout: bit 7 sync error, 6 CRC error, 5 uncorrectable ECC, 4 correctable ECC, 3 low-level protocol error, 2 start-of-transmission error, 0 PLL unlock. The flag for bit i sets at the edge after `err_evt_in[i]` is high and stays set. Bit 1 never sets.
- R8: Writing 0xE5 clears each flag whose write-data bit is 1 and leaves the other flags alone. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R9: `irq_out` is high exactly when the global enable is set and at least one status flag has its enable bit set. It follows the register state with no further delay.
- R10: Reads of unimplemented addresses (for example 0x0C, 0x50, 0xE6) return 0x00. Writes to them change no register.
- R11: `rdata` carries the addressed byte in the cycle after a cycle with `rd_en` high. In any other cycle it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after rd_en |
| pll_lock_in | input | 1 | Lock level from the PLL model |
| err_evt_in | input | 8 | Error event pulses, one bit per status flag |
| soft_reset_out | output | 1 | One-cycle soft reset request |
| pll_en_out | output | 1 | PLL enable |
| clk_range_out | output | 3 | Selected output clock range |
| clk_src_out | output | 1 | Reference clock source select |
| pll_locked_out | output | 1 | Qualified lock flag |
| irq_out | output | 1 | Level interrupt |

## Verification
A register write or a status event takes effect at the first clock edge that sees it. So `soft_reset_out`, `pll_en_out`, the clock-range outputs, the lock flag and `irq_out` are all checked on the falling edge right after that edge. A read result is due one cycle after its strobe. The driver queues the expected byte when it raises `rd_en`, and the monitor pops and compares it on the falling edge after the capturing rising edge. The one-cycle width of the soft reset pulse is checked at the falling edge after that. The lock flag is checked after `pll_lock_in` has been registered once.

// File: rtl/cfg_pkg.sv
// Package: address map, status bit positions and widths shared by the
// configuration register file and its checker.
package cfg_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int N_ID   = 9;

    localparam logic [ADDR_W-1:0] A_RESET  = 8'h09;
    localparam logic [ADDR_W-1:0] A_CLKCFG = 8'h0A;
    localparam logic [ADDR_W-1:0] A_PLLEN  = 8'h0D;
    localparam logic [ADDR_W-1:0] A_IRQGLB = 8'hE0;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 8'hE1;
    localparam logic [ADDR_W-1:0] A_IRQST  = 8'hE5;

    // Status layout: 7 sync, 6 crc, 5 ecc-unc, 4 ecc-cor, 3 protocol,
    // 2 start-of-transmission, 0 pll unlock; bit 1 unused.
    localparam logic [DATA_W-1:0] STAT_MASK = 8'hFD;
endpackage

// File: rtl/cfg_id_bytes.sv
// Module: cfg_id_bytes
// Decodes the read-only identification window. Purely combinational.
// Assumes the ID bytes are packed little-end first in ID_VALUE.
module cfg_id_bytes
    import cfg_pkg::*;
#(
    parameter int N_BYTES = N_ID,
    parameter logic [8*N_BYTES-1:0] ID_VALUE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    // Select the ID byte matching the address, if any.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (addr == ADDR_W'(i)) begin
                hit  = 1'b1;
                data = ID_VALUE[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/cfg_ctrl_regs.sv
// Module: cfg_ctrl_regs
// Reset, clock-configuration and PLL-enable registers plus the lock flag.
// Assumes pll_lock_in is already synchronous to clk.
module cfg_ctrl_regs
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pll_lock_in,
    output logic              soft_reset,
    output logic              pll_en,
    output logic [2:0]        clk_range,
    output logic              clk_src,
    output logic              locked,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    logic lock_raw_q;

    // Soft reset bit: set by a write, cleared on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            soft_reset <= 1'b0;
        else if (wr_en && addr == A_RESET)
            soft_reset <= wdata[0];
        else
            soft_reset <= 1'b0;
    end

    // Clock range / source and PLL enable, plain read-write fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_range <= '0;
            clk_src   <= 1'b0;
            pll_en    <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CLKCFG) begin
                clk_range <= wdata[3:1];
                clk_src   <= wdata[0];
            end
            if (addr == A_PLLEN)
                pll_en <= wdata[0];
        end
    end

    // Register the raw lock level once.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_raw_q <= 1'b0;
        else        lock_raw_q <= pll_lock_in;
    end

    // Lock is only reported while the PLL is enabled.
    assign locked = lock_raw_q & pll_en;

    // Read decode for this register group.
    always_comb begin
        hit  = 1'b1;
        data = '0;
        unique case (addr)
            A_RESET:  data = {7'b0, soft_reset};
            A_CLKCFG: data = {locked, 3'b000, clk_range, clk_src};
            A_PLLEN:  data = {7'b0, pll_en};
            default:  hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_irq_regs.sv
// Module: cfg_irq_regs
// Global enable, per-source enables and sticky write-one-to-clear status.
// Assumes err_evt_in is synchronous; an event beats a clear in one cycle.
module cfg_irq_regs
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] err_evt_in,
    output logic              irq,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    logic              gie_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] clr_mask;

    // Enable registers; unused bit positions are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            en_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_IRQGLB) gie_q <= wdata[0];
            if (addr == A_IRQEN)  en_q  <= wdata & STAT_MASK;
        end
    end

    // Bits to clear this cycle from a status write.
    assign clr_mask = (wr_en && addr == A_IRQST) ? wdata : '0;

    // Sticky status: events set, ones written clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_mask) | err_evt_in) & STAT_MASK;
    end

    // Level interrupt from current register state.
    assign irq = gie_q & (|(stat_q & en_q));

    // Read decode for this register group.
    always_comb begin
        hit  = 1'b1;
        data = '0;
        unique case (addr)
            A_IRQGLB: data = {7'b0, gie_q};
            A_IRQEN:  data = en_q;
            A_IRQST:  data = stat_q;
            default:  hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/bridge_cfg_regs.sv
// Module: bridge_cfg_regs
// Top of the bridge configuration register file: ID window, control group
// and interrupt group behind one registered read port.
// Assumes at most one access strobe matters per cycle; reads are side-effect free.
module bridge_cfg_regs
    import cfg_pkg::*;
#(
    parameter logic [8*N_ID-1:0] ID_VALUE = 72'h20_20_20_20_33_38_49_53_44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pll_lock_in,
    input  logic [DATA_W-1:0] err_evt_in,
    output logic              soft_reset_out,
    output logic              pll_en_out,
    output logic [2:0]        clk_range_out,
    output logic              clk_src_out,
    output logic              pll_locked_out,
    output logic              irq_out
);
    logic              id_hit, ctl_hit, irq_hit;
    logic [DATA_W-1:0] id_data, ctl_data, irq_data, rd_mux;

    cfg_id_bytes #(.N_BYTES(N_ID), .ID_VALUE(ID_VALUE)) u_id (
        .addr (addr),
        .hit  (id_hit),
        .data (id_data)
    );

    cfg_ctrl_regs u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .pll_lock_in (pll_lock_in),
        .soft_reset  (soft_reset_out),
        .pll_en      (pll_en_out),
        .clk_range   (clk_range_out),
        .clk_src     (clk_src_out),
        .locked      (pll_locked_out),
        .hit         (ctl_hit),
        .data        (ctl_data)
    );

    cfg_irq_regs u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .err_evt_in (err_evt_in),
        .irq        (irq_out),
        .hit        (irq_hit),
        .data       (irq_data)
    );

    // Merge the group read data; unmatched addresses give zero.
    always_comb begin
        rd_mux = '0;
        if (id_hit)  rd_mux = id_data;
        if (ctl_hit) rd_mux = ctl_data;
        if (irq_hit) rd_mux = irq_data;
    end

    // Registered read port: data one cycle after the strobe, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end
endmodule

// File: rtl/cfg_regs_checker.sv
// Module: cfg_regs_checker
// Temporal properties on the register file's ports; bound to the top.
module cfg_regs_checker
    import cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              soft_reset_out,
    input logic              pll_en_out,
    input logic              pll_locked_out,
    input logic              irq_out
);
    // R3: a soft reset request lasts a single cycle unless rewritten.
    assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset_out && !(wr_en && addr == A_RESET)) |=> !soft_reset_out);

    // R3: writing one to the reset bit raises the request.
    assert_reset_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RESET && wdata[0]) |=> soft_reset_out);

    // R5: PLL enable follows a write to its register.
    assert_pll_en_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PLLEN) |=> (pll_en_out == $past(wdata[0])));

    // R5: lock drops at the same edge as the enable.
    assert_lock_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en_out) |-> !pll_locked_out);

    // R8: the interrupt is sticky without a write to the interrupt registers.
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !(wr_en && (addr == A_IRQGLB || addr == A_IRQEN || addr == A_IRQST)))
        |=> irq_out);
endmodule

bind bridge_cfg_regs cfg_regs_checker u_chk (.*);

// File: tb/sim_bridge_cfg_regs.sv
module sim_bridge_cfg_regs;
    localparam logic [71:0] IDV = 72'h20_20_20_20_33_38_49_53_44;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       pll_lock_in = 1'b0;
    logic [7:0] err_evt_in = '0;
    logic       soft_reset_out, pll_en_out, clk_src_out, pll_locked_out, irq_out;
    logic [2:0] clk_range_out;

    int  n_checks = 0, n_fails = 0;
    bit  done = 0;
    logic rd_d = 1'b0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    bridge_cfg_regs #(.ID_VALUE(IDV)) u0 (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: capture read strobe, then compare the popped expectation.
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d && q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ev);
        wr_en = 1; addr = a; wdata = d; err_evt_in = ev;
        @(negedge clk);
        wr_en = 0; err_evt_in = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1; addr = a;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
    endtask

    task automatic evt(input logic [7:0] ev);
        err_evt_in = ev;
        @(negedge clk);
        err_evt_in = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs", {2'b0, soft_reset_out, pll_en_out, pll_locked_out, irq_out, clk_src_out, 1'b0}, 8'h00);
        check("R1 range", {5'b0, clk_range_out}, 8'h00);
        rd(8'h0A, 8'h00, "R1 clkcfg");
        rd(8'hE5, 8'h00, "R1 status");
        rd(8'hE1, 8'h00, "R1 enables");
        // R11: idle read port is zero
        check("R11 idle rdata", rdata, 8'h00);

        // R2: ID bytes, writes ignored
        for (int i = 0; i < 9; i++) rd(8'(i), IDV[i*8 +: 8], "R2 id byte");
        wr(8'h03, 8'hFF);
        rd(8'h03, IDV[31:24], "R2 id write ignored");

        // R3: soft reset pulse
        wr(8'h09, 8'h01);
        check("R3 pulse high", {7'b0, soft_reset_out}, 8'h01);
        @(negedge clk);
        check("R3 pulse low", {7'b0, soft_reset_out}, 8'h00);
        rd(8'h09, 8'h00, "R3 self clear");

        // R4: clock config fields, lock bit not writable
        wr(8'h0A, 8'hFF);
        check("R4 range", {5'b0, clk_range_out}, 8'h07);
        check("R4 src", {7'b0, clk_src_out}, 8'h01);
        rd(8'h0A, 8'h0F, "R4 readback");
        wr(8'h0A, 8'h04);
        check("R4 range 2", {5'b0, clk_range_out}, 8'h02);

        // R5: lock qualified by enable
        pll_lock_in = 1;
        @(negedge clk); @(negedge clk);
        check("R5 lock gated", {7'b0, pll_locked_out}, 8'h00);
        rd(8'h0A, 8'h04, "R5 lock gated rd");
        wr(8'h0D, 8'h01);
        check("R5 pll_en", {7'b0, pll_en_out}, 8'h01);
        check("R5 locked", {7'b0, pll_locked_out}, 8'h01);
        rd(8'h0A, 8'h84, "R5 lock bit");
        pll_lock_in = 0;
        @(negedge clk);
        check("R5 lock lost", {7'b0, pll_locked_out}, 8'h00);
        pll_lock_in = 1;
        @(negedge clk);
        wr(8'h0D, 8'h00);
        check("R5 disable drops lock", {7'b0, pll_locked_out}, 8'h00);
        rd(8'h0D, 8'h00, "R5 en readback");

        // R6: enables
        wr(8'hE0, 8'h01);
        wr(8'hE1, 8'hFF);
        rd(8'hE1, 8'hFD, "R6 enable bit1 zero");
        rd(8'hE0, 8'h01, "R6 global");

        // R7 / R9: events set sticky flags and raise irq
        check("R9 irq idle", {7'b0, irq_out}, 8'h00);
        evt(8'hFF);
        check("R9 irq set", {7'b0, irq_out}, 8'h01);
        @(negedge clk);
        rd(8'hE5, 8'hFD, "R7 sticky layout");

        // R8: write back clears reported flags
        wr(8'hE5, 8'hFD);
        check("R9 irq cleared", {7'b0, irq_out}, 8'h00);
        rd(8'hE5, 8'h00, "R8 write back clear");
        evt(8'h84);
        wr(8'hE5, 8'h04);
        rd(8'hE5, 8'h80, "R8 partial clear");
        wr_evt(8'hE5, 8'h80, 8'h80);
        rd(8'hE5, 8'h80, "R8 event wins");

        // R9: gating by global and per-source enables
        wr(8'hE0, 8'h00);
        check("R9 global off", {7'b0, irq_out}, 8'h00);
        wr(8'hE0, 8'h01);
        check("R9 global on", {7'b0, irq_out}, 8'h01);
        wr(8'hE1, 8'h7F);
        check("R9 source masked", {7'b0, irq_out}, 8'h00);
        wr(8'hE5, 8'hFF);

        // R10: unimplemented addresses
        wr(8'h50, 8'hAA);
        wr(8'h0C, 8'hAA);
        rd(8'h50, 8'h00, "R10 read 0x50");
        rd(8'h0C, 8'h00, "R10 read 0x0C");
        rd(8'hE6, 8'h00, "R10 read 0xE6");
        rd(8'hE1, 8'h7D, "R10 neighbours untouched");

        @(negedge clk);
        check("R11 rdata after read", rdata, 8'h00);
        done = 1;
        summary();
        $finish;
    end
endmodule